// File: doc/BRIEF.md
# Two-Window Watchdog Timer

This block is a watchdog timer that software reaches through a small memory-mapped register bus. Software loads two window lengths, counted in clock cycles, and sets an enable bit. The timer then runs through the first window and the second window in turn. The end of the first window raises a sticky interrupt, which gives software a warning. The end of the second window raises a reset request pulse for the system. A refresh write starts the sequence again from the top of the first window. Software that keeps refreshing in time never sees the reset.

The bus has a single write strobe. Read data is a combinational function of the address. All timing counts from the clock edge that accepts a write. A window of length N ends on the N-th clock edge after the edge that started it, and a length of 0 acts like a length of 1. After the second window ends, the timer stays in a spent state. It does nothing more until software refreshes it or enables it again.

Top module: `twwd_top`

## Requirements
- R1: After reset, `win1_irq` and `sys_rst_req` are low, and every register reads 0.
- R2: The register map is: control/status at 0x2000, second-window length at 0x2008, first-window length at 0x2010, and two spare words at 0x2014 and 0x2FD0. Writes to the window registers keep the low CNT_W bits, and reads return those bits zero-extended. The spare words read back the full word last written. The refresh address 0x1000 and all unmapped addresses read 0.
- R3: A write to 0x2000 with bit 0 = 1 while the timer is disabled starts the first window. For a first-window length N ≥ 1, `win1_irq` rises on the N-th edge after the write edge. A write of bit 0 = 1 while the timer is already enabled does not restart it.
- R4: Control/status bit 1 is the sticky interrupt flag, and `win1_irq` follows it. The end of the first window sets it. Writing 1 to bit 1 clears it, writing 0 leaves it unchanged, and a set in the same cycle as a clear wins. Bit 0 reads back the enable.
- R5: When the first window ends, the second window starts with the length in 0x2008. When the second window ends, `sys_rst_req` goes high for exactly RST_CYC cycles, starting on that edge.
- R6: A write to 0x1000 with bit 0 = 1 while enabled restarts the first window from its full length. A reset request that was due later does not come. A refresh write with bit 0 = 0 has no effect.
- R7: Writing 0 to control bit 0 stops the timer from the write edge on. While the timer is disabled, no interrupt and no reset request are produced, and refresh writes have no effect.
- R8: A window length of 0 ends that window on the first edge after it starts.
- R9: After the second window has ended, the timer produces no further interrupt or reset request until a refresh or a new enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | ADDR_W | Byte address for writes and reads |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| win1_irq | output | 1 | Sticky first-window interrupt |
| sys_rst_req | output | 1 | Reset request pulse, RST_CYC cycles wide |

## Verification
The bench builds the block with CNT_W = 12 and the default RST_CYC = 16. With these values, truncation of window writes to the counter width can be checked by readback. They also keep whole two-window sequences, including the full reset pulse and its trailing edge, short enough to trace cycle by cycle many times. Random window lengths from 0 to 20, together with refreshes at random cycles, reach the cases where a restart lands exactly on a window's final edge. Those random refreshes are mixed with directed runs for zero-length windows, disabling in mid-window and the spent state.

// File: rtl/twwd_pkg.sv
package twwd_pkg;

  localparam logic [31:0] OFS_KICK  = 32'h0000_1000;
  localparam logic [31:0] OFS_CTRL  = 32'h0000_2000;
  localparam logic [31:0] OFS_LEN2  = 32'h0000_2008;
  localparam logic [31:0] OFS_LEN1  = 32'h0000_2010;
  localparam logic [31:0] OFS_SPARE = 32'h0000_2014;
  localparam logic [31:0] OFS_WARM  = 32'h0000_2FD0;

  localparam int CTRL_EN_BIT  = 0;
  localparam int CTRL_IRQ_BIT = 1;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_WIN1 = 2'd1,
    PH_WIN2 = 2'd2,
    PH_DONE = 2'd3
  } phase_t;

  // A window ends on the edge where its remaining count is 0 or 1.
  function automatic logic window_ends(input logic [63:0] remaining);
    return remaining <= 64'd1;
  endfunction

  function automatic logic addr_is(input logic [31:0] a, input logic [31:0] ofs);
    return a == ofs;
  endfunction

endpackage

// File: rtl/twwd_regs.sv
module twwd_regs
  import twwd_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              win1_exp,
  output logic              en_q,
  output logic              en_next,
  output logic              start_p,
  output logic              refresh_p,
  output logic              irq_q,
  output logic [CNT_W-1:0]  len1_q,
  output logic [CNT_W-1:0]  len2_q
);

  logic [31:0]       addr_ext;
  logic              wr_ctrl, wr_kick, wr_len1, wr_len2, wr_spare, wr_warm;
  logic              irq_clr;
  logic [DATA_W-1:0] spare_q, warm_q;

  assign addr_ext = 32'(bus_addr);

  always_comb begin
    wr_ctrl  = bus_wr && addr_is(addr_ext, OFS_CTRL);
    wr_kick  = bus_wr && addr_is(addr_ext, OFS_KICK);
    wr_len1  = bus_wr && addr_is(addr_ext, OFS_LEN1);
    wr_len2  = bus_wr && addr_is(addr_ext, OFS_LEN2);
    wr_spare = bus_wr && addr_is(addr_ext, OFS_SPARE);
    wr_warm  = bus_wr && addr_is(addr_ext, OFS_WARM);
  end

  assign en_next   = wr_ctrl ? bus_wdata[CTRL_EN_BIT] : en_q;
  assign start_p   = wr_ctrl && bus_wdata[CTRL_EN_BIT] && !en_q;
  assign refresh_p = wr_kick && bus_wdata[0] && en_q;
  assign irq_clr   = wr_ctrl && bus_wdata[CTRL_IRQ_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      irq_q   <= 1'b0;
      len1_q  <= '0;
      len2_q  <= '0;
      spare_q <= '0;
      warm_q  <= '0;
    end else begin
      en_q <= en_next;
      if (win1_exp)     irq_q <= 1'b1;
      else if (irq_clr) irq_q <= 1'b0;
      if (wr_len1)  len1_q  <= bus_wdata[CNT_W-1:0];
      if (wr_len2)  len2_q  <= bus_wdata[CNT_W-1:0];
      if (wr_spare) spare_q <= bus_wdata;
      if (wr_warm)  warm_q  <= bus_wdata;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (addr_is(addr_ext, OFS_CTRL)) begin
      bus_rdata[CTRL_EN_BIT]  = en_q;
      bus_rdata[CTRL_IRQ_BIT] = irq_q;
    end else if (addr_is(addr_ext, OFS_LEN1)) begin
      bus_rdata = DATA_W'(len1_q);
    end else if (addr_is(addr_ext, OFS_LEN2)) begin
      bus_rdata = DATA_W'(len2_q);
    end else if (addr_is(addr_ext, OFS_SPARE)) begin
      bus_rdata = spare_q;
    end else if (addr_is(addr_ext, OFS_WARM)) begin
      bus_rdata = warm_q;
    end
  end

  // R4: the end of window one always leaves the flag set
  a_r4_irq_set: assert property (@(posedge clk) disable iff (!rst_n)
    win1_exp |=> irq_q);

  // R4: a write-one clear without a competing set drops the flag
  a_r4_irq_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr && !win1_exp) |=> !irq_q);

endmodule

// File: rtl/twwd_seq.sv
module twwd_seq
  import twwd_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_p,
  input  logic             refresh_p,
  input  logic             run,
  input  logic [CNT_W-1:0] len1,
  input  logic [CNT_W-1:0] len2,
  output phase_t           phase,
  output logic             win1_exp,
  output logic             win2_exp
);

  logic [CNT_W-1:0] remain;
  logic             restart, ticking, at_end;

  always_comb begin
    restart  = start_p || refresh_p;
    ticking  = run && !restart;
    at_end   = window_ends(64'(remain));
    win1_exp = ticking && (phase == PH_WIN1) && at_end;
    win2_exp = ticking && (phase == PH_WIN2) && at_end;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      remain <= '0;
    end else if (restart) begin
      phase  <= PH_WIN1;
      remain <= len1;
    end else if (!run) begin
      phase  <= PH_IDLE;
    end else begin
      case (phase)
        PH_WIN1: begin
          if (at_end) begin
            phase  <= PH_WIN2;
            remain <= len2;
          end else begin
            remain <= remain - CNT_W'(1);
          end
        end
        PH_WIN2: begin
          if (at_end) phase <= PH_DONE;
          else        remain <= remain - CNT_W'(1);
        end
        default: ;
      endcase
    end
  end

  // R3: an enable from the disabled state loads window one
  a_r3_start_loads: assert property (@(posedge clk) disable iff (!rst_n)
    start_p |=> (phase == PH_WIN1) && (remain == $past(len1)));

  // R6: a refresh reloads window one from its full length
  a_r6_refresh_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_p |=> (phase == PH_WIN1) && (remain == $past(len1)));

  // R9: once spent, only a restart leaves the spent state for a window
  a_r9_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase == PH_DONE) && !restart) |=> (phase == PH_DONE || phase == PH_IDLE));

endmodule

// File: rtl/twwd_rstgen.sv
module twwd_rstgen #(
  parameter int RST_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trigger,
  output logic pulse
);

  localparam int HOLD_W = $clog2(RST_CYC + 1);

  logic [HOLD_W-1:0] hold;
  logic [15:0]       hi_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           hold <= '0;
    else if (trigger)     hold <= HOLD_W'(RST_CYC);
    else if (hold != '0)  hold <= hold - HOLD_W'(1);
  end

  assign pulse = (hold != '0);

  // length of the current high stretch, kept only for the check below
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     hi_len <= '0;
    else if (pulse) hi_len <= hi_len + 16'(hi_len != 16'hFFFF);
    else            hi_len <= '0;
  end

  // R5: a reset request never ends before RST_CYC cycles
  a_r5_pulse_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pulse) |-> (hi_len >= 16'(RST_CYC)));

endmodule

// File: rtl/twwd_top.sv
module twwd_top
  import twwd_pkg::*;
#(
  parameter int ADDR_W  = 14,
  parameter int DATA_W  = 32,
  parameter int CNT_W   = 32,
  parameter int RST_CYC = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              win1_irq,
  output logic              sys_rst_req
);

  logic             en_q, en_next, start_p, refresh_p, irq_q;
  logic             win1_exp, win2_exp;
  logic [CNT_W-1:0] len1_q, len2_q;
  phase_t           phase;

  twwd_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .win1_exp(win1_exp),
    .en_q(en_q), .en_next(en_next), .start_p(start_p),
    .refresh_p(refresh_p), .irq_q(irq_q),
    .len1_q(len1_q), .len2_q(len2_q)
  );

  twwd_seq #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .start_p(start_p), .refresh_p(refresh_p), .run(en_next),
    .len1(len1_q), .len2(len2_q),
    .phase(phase), .win1_exp(win1_exp), .win2_exp(win2_exp)
  );

  twwd_rstgen #(.RST_CYC(RST_CYC)) u_rstgen (
    .clk(clk), .rst_n(rst_n),
    .trigger(win2_exp), .pulse(sys_rst_req)
  );

  assign win1_irq = irq_q;

  // R7: nothing expires while disabled and not being enabled
  a_r7_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !start_p) |-> (!win1_exp && !win2_exp));

  // R5: a reset request only starts out of window two
  a_r5_rst_after_win2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_req) |-> ($past(phase) == PH_WIN2));

endmodule

// File: tb/tb_twwd_top.sv
module tb_twwd_top;

  localparam int ADDR_W  = 14;
  localparam int DATA_W  = 32;
  localparam int CNT_W   = 12;
  localparam int RST_CYC = 16;

  localparam logic [ADDR_W-1:0] A_KICK  = 14'h1000;
  localparam logic [ADDR_W-1:0] A_CTRL  = 14'h2000;
  localparam logic [ADDR_W-1:0] A_LEN2  = 14'h2008;
  localparam logic [ADDR_W-1:0] A_LEN1  = 14'h2010;
  localparam logic [ADDR_W-1:0] A_SPARE = 14'h2014;
  localparam logic [ADDR_W-1:0] A_WARM  = 14'h2FD0;
  localparam logic [ADDR_W-1:0] A_HOLE  = 14'h2004;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              bus_wr = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic [DATA_W-1:0] bus_rdata;
  logic              win1_irq, sys_rst_req;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  twwd_top #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .RST_CYC(RST_CYC)) dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .win1_irq(win1_irq), .sys_rst_req(sys_rst_req)
  );

  function automatic int eff_len(input int n);
    return (n == 0) ? 1 : n;
  endfunction

  function automatic int first_irq_at(input int e1, input int r);
    return (r != 0 && r <= e1) ? r + e1 : e1;
  endfunction

  function automatic int rst_start_at(input int e1, input int e2, input int r);
    return (r != 0) ? r + e1 + e2 : e1 + e2;
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  // Program both windows, enable, optionally refresh at cycle r, trace outputs.
  task automatic run_case(input string req, input int n1, input int n2,
                          input int r, input bit kick_bit);
    int e1, e2, er, fi, rs, kmax;
    wr(A_CTRL, 32'h2);
    wr(A_LEN1, 32'(n1));
    wr(A_LEN2, 32'(n2));
    wr(A_CTRL, 32'h1);
    e1 = eff_len(n1);
    e2 = eff_len(n2);
    er = kick_bit ? r : 0;
    fi = first_irq_at(e1, er);
    rs = rst_start_at(e1, e2, er);
    kmax = rs + RST_CYC + 4;
    for (int k = 1; k <= kmax; k++) begin
      if (k == r) begin
        bus_wr = 1'b1; bus_addr = A_KICK; bus_wdata = {31'd0, kick_bit};
      end else begin
        bus_wr = 1'b0; bus_wdata = '0;
      end
      @(negedge clk);
      check(req, $sformatf("irq n1=%0d n2=%0d r=%0d k=%0d", n1, n2, r, k),
            32'(win1_irq), 32'(k >= fi));
      check(req, $sformatf("rst n1=%0d n2=%0d r=%0d k=%0d", n1, n2, r, k),
            32'(sys_rst_req), 32'(k >= rs && k < rs + RST_CYC));
    end
    bus_wr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd4242));
    tick(3);
    rst_n = 1'b1;
    tick(1);

    // R1: reset state
    check("R1", "irq after reset", 32'(win1_irq), 0);
    check("R1", "rst after reset", 32'(sys_rst_req), 0);
    rd(A_CTRL, v);  check("R1", "ctrl", v, 0);
    rd(A_LEN1, v);  check("R1", "len1", v, 0);
    rd(A_LEN2, v);  check("R1", "len2", v, 0);
    rd(A_SPARE, v); check("R1", "spare", v, 0);
    rd(A_WARM, v);  check("R1", "warm", v, 0);

    // R2: map, truncation, readback
    wr(A_LEN1, 32'h0001_2345);  rd(A_LEN1, v);  check("R2", "len1 trunc", v, 32'h345);
    wr(A_LEN2, 32'hFFFF_FABC);  rd(A_LEN2, v);  check("R2", "len2 trunc", v, 32'hABC);
    wr(A_SPARE, 32'hDEAD_BEEF); rd(A_SPARE, v); check("R2", "spare", v, 32'hDEAD_BEEF);
    wr(A_WARM, 32'h1234_5678);  rd(A_WARM, v);  check("R2", "warm", v, 32'h1234_5678);
    wr(A_HOLE, 32'hFFFF_FFFF);  rd(A_HOLE, v);  check("R2", "unmapped", v, 0);
    rd(A_KICK, v); check("R2", "kick reads zero", v, 0);
    rd(A_LEN1, v); check("R2", "len1 kept", v, 32'h345);

    // R3 R4 R5: directed sequence, windows 5 and 3
    wr(A_LEN1, 32'd5);
    wr(A_LEN2, 32'd3);
    wr(A_CTRL, 32'h1);
    tick(3);
    check("R3", "irq low before end", 32'(win1_irq), 0);
    wr(A_CTRL, 32'h1);
    check("R3", "irq at edge 4 (re-enable no restart)", 32'(win1_irq), 0);
    tick(1);
    check("R3", "irq at edge 5", 32'(win1_irq), 1);
    rd(A_CTRL, v); check("R4", "ctrl en+irq", v, 32'h3);
    tick(2);
    check("R5", "rst low at edge 7", 32'(sys_rst_req), 0);
    tick(1);
    check("R5", "rst high at edge 8", 32'(sys_rst_req), 1);
    tick(15);
    check("R5", "rst high at edge 23", 32'(sys_rst_req), 1);
    tick(1);
    check("R5", "rst low at edge 24", 32'(sys_rst_req), 0);

    // R9: spent state stays quiet
    begin
      int hits = 0;
      for (int i = 0; i < 40; i++) begin
        tick(1);
        if (sys_rst_req) hits++;
      end
      check("R9", "no reset after spent", 32'(hits), 0);
    end
    wr(A_CTRL, 32'h1);
    rd(A_CTRL, v); check("R4", "write 0 keeps irq", v, 32'h3);
    wr(A_CTRL, 32'h3);
    rd(A_CTRL, v); check("R4", "w1c clears irq", v, 32'h1);
    tick(30);
    check("R9", "irq stays clear when spent", 32'(win1_irq), 0);
    check("R9", "rst stays low when spent", 32'(sys_rst_req), 0);

    // R6: refresh rescues, and a zero-bit refresh is ignored
    run_case("R6", 10, 6, 12, 1'b1);
    run_case("R6", 10, 6, 3, 1'b0);
    run_case("R6", 8, 4, 8, 1'b1);

    // R8: zero-length windows
    run_case("R8", 0, 0, 0, 1'b0);
    run_case("R8", 0, 5, 0, 1'b0);

    // R7: disabled timer is inert, disable stops mid-window
    wr(A_CTRL, 32'h2);
    wr(A_LEN1, 32'd2);
    wr(A_LEN2, 32'd2);
    wr(A_KICK, 32'h1);
    tick(30);
    check("R7", "no irq while off", 32'(win1_irq), 0);
    check("R7", "no rst while off", 32'(sys_rst_req), 0);
    wr(A_LEN1, 32'd10);
    wr(A_CTRL, 32'h1);
    tick(2);
    wr(A_CTRL, 32'h0);
    tick(40);
    check("R7", "no irq after mid-window stop", 32'(win1_irq), 0);
    check("R7", "no rst after mid-window stop", 32'(sys_rst_req), 0);
    wr(A_KICK, 32'h1);
    tick(40);
    check("R7", "refresh while off ignored", 32'(win1_irq), 0);

    // R3 R5 R6 R8: random runs
    for (int it = 0; it < 24; it++) begin
      int n1, n2, r;
      bit kb;
      n1 = $urandom_range(0, 20);
      n2 = $urandom_range(0, 20);
      r  = ($urandom_range(0, 2) != 0)
           ? $urandom_range(1, eff_len(n1) + eff_len(n2) - 1) : 0;
      kb = ($urandom_range(0, 3) != 0);
      run_case("R6", n1, n2, r, kb);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule